// File: doc/BRIEF.md
# Cycle-Stealing Block Transfer Engine

This block moves a block of words between one attached device and main memory on its own, so the processor does not have to copy each word. Software sets a transfer direction, a device select value, a first memory address and a word count through a small register port, then writes a go bit. From then on the engine works one word at a time. It waits for the device to offer a word or accept one. It then asks for the shared bus and, once granted, holds it for exactly one bus cycle, in which that word crosses between memory and the device. It then lets the bus go again.

The processor is never interrupted while words move. It only loses the bus for the single cycles that the engine owns. The engine sits next to the device, so each word uses the system bus once: a memory write when the device supplies data, or a memory read whose data goes straight to the device. When the last word is done, the engine sets a done flag and raises an interrupt line. A status read clears that line.

Top module: `cyc_steal_dma`

## Requirements
- R1: After reset the engine is idle: `irq` and `bus_req` are low, and the status, address and count registers all read zero.
- R2: Register map on `reg_addr`: 0 = control (bit 0 go, self-clearing and read as 0; bit 1 direction, 0 = device to memory, 1 = memory to device), 1 = device select, 2 = memory address, 3 = word count, 4 = status (bit 0 busy, bit 1 done, bit 2 interrupt pending). Reads are combinational.
- R3: Device to memory: each word the device offers with `dev_rvalid` is taken with a one-cycle `dev_rack` and written to memory with one bus write cycle (`bus_we`) at consecutive addresses.
- R4: Memory to device: each word is read in one bus read cycle (`bus_re`), and the data read goes to `dev_wdata` with a one-cycle `dev_wstrobe` in that same cycle.
- R5: The bus is driven (`bus_we` or `bus_re`) only in a cycle where `bus_req` and `bus_gnt` are both high. Each ownership lasts one cycle, and `bus_req` is low in the cycle after it, so no two owned cycles are adjacent.
- R6: After each word the memory address register rises by one and the count register falls by one. Both stay readable.
- R7: When the count reaches zero, busy clears, done sets, and `irq` goes high.
- R8: A read of the status register clears `irq` at the end of that read cycle. The done bit stays set until the next go.
- R9: While busy, writes to any register are ignored: the address, count and direction stay as they were, and a second go starts nothing.
- R10: A go with a word count of zero sets done and raises `irq` at once, with no bus request and no bus cycle.
- R11: The engine does not request the bus until the device has signalled a valid word (device to memory) or readiness (memory to device).
- R12: While waiting for a grant, the engine keeps `bus_req` high and drives no bus cycle, however long the grant takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data |
| irq | output | 1 | Block-complete interrupt |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_addr | output | AW | Memory address, valid in the owned cycle |
| bus_we | output | 1 | Memory write strobe |
| bus_re | output | 1 | Memory read strobe |
| bus_wdata | output | DW | Memory write data |
| bus_rdata | input | DW | Memory read data, valid in the same cycle |
| dev_sel | output | DEVW | Programmed device select |
| dev_rvalid | input | 1 | Device has a word for memory |
| dev_rdata | input | DW | Device word |
| dev_rack | output | 1 | Device word taken |
| dev_wready | input | 1 | Device can take a word |
| dev_wdata | output | DW | Word for the device |
| dev_wstrobe | output | 1 | Word for the device is valid |

## Verification
The bench checks the zero-count start. A design that falls into its normal path there would request the bus and count down below zero, writing across memory. It holds the grant back for many cycles. A design that reads a stale grant, or drives the bus while only requesting, would show bus cycles without a grant. It keeps the device idle while the engine is busy and pokes every register in that window. A design that accepts those writes would move the words to the wrong place or in the wrong direction. It also counts owned cycles per block and looks for owned cycles back to back. A design that held the bus in a burst, or that crossed the bus twice per word, would give the wrong count.

// File: rtl/dma_pkg.sv
// Shared definitions for the cycle-stealing transfer engine.
// Assumes: 3-bit register offsets; bit positions below are software visible.
package dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_DEV,
        ST_REQ,
        ST_XFER
    } seq_state_t;

    localparam logic [2:0] OFS_CTRL  = 3'd0;
    localparam logic [2:0] OFS_DEV   = 3'd1;
    localparam logic [2:0] OFS_MADDR = 3'd2;
    localparam logic [2:0] OFS_COUNT = 3'd3;
    localparam logic [2:0] OFS_STAT  = 3'd4;

    localparam int CTRL_GO  = 0;
    localparam int CTRL_DIR = 1;
    localparam int STS_BUSY = 0;
    localparam int STS_DONE = 1;
    localparam int STS_IRQ  = 2;

endpackage

// File: rtl/dma_regs.sv
// Register port: holds the direction and device select, and produces load
// strobes for the address/count counters. Keeps the done flag and the
// interrupt line. Assumes DW >= 3 and DW >= DEVW; all writes are dropped
// while the sequencer is busy.
module dma_regs
    import dma_pkg::*;
#(
    parameter int DW   = 16,
    parameter int AW   = 16,
    parameter int CW   = 16,
    parameter int DEVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [2:0]      reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic            busy,
    input  logic            done_pulse,
    input  logic [AW-1:0]   cur_addr,
    input  logic [CW-1:0]   cur_cnt,
    output logic            go,
    output logic            dir,
    output logic [DEVW-1:0] dev_sel,
    output logic            ld_addr,
    output logic            ld_cnt,
    output logic            irq
);

    logic wr_ok;
    logic sts_rd;
    logic done_q;

    // Qualify writes: nothing lands while a block is in flight.
    always_comb begin
        wr_ok   = reg_wr && !busy;
        go      = wr_ok && (reg_addr == OFS_CTRL) && reg_wdata[CTRL_GO];
        ld_addr = wr_ok && (reg_addr == OFS_MADDR);
        ld_cnt  = wr_ok && (reg_addr == OFS_COUNT);
        sts_rd  = reg_rd && (reg_addr == OFS_STAT);
    end

    // Direction and device select storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir     <= 1'b0;
            dev_sel <= '0;
        end else if (wr_ok) begin
            if (reg_addr == OFS_CTRL) dir     <= reg_wdata[CTRL_DIR];
            if (reg_addr == OFS_DEV)  dev_sel <= DEVW'(reg_wdata);
        end
    end

    // Done flag: set on completion, cleared by the next go.
    always_ff @(posedge clk) begin
        if (!rst_n)          done_q <= 1'b0;
        else if (done_pulse) done_q <= 1'b1;
        else if (go)         done_q <= 1'b0;
    end

    // Interrupt line: set on completion, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)          irq <= 1'b0;
        else if (done_pulse) irq <= 1'b1;
        else if (sts_rd)     irq <= 1'b0;
    end

    // Read mux; the counters are read live.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL:  reg_rdata[CTRL_DIR] = dir;
            OFS_DEV:   reg_rdata = DW'(dev_sel);
            OFS_MADDR: reg_rdata = DW'(cur_addr);
            OFS_COUNT: reg_rdata = DW'(cur_cnt);
            OFS_STAT: begin
                reg_rdata[STS_BUSY] = busy;
                reg_rdata[STS_DONE] = done_q;
                reg_rdata[STS_IRQ]  = irq;
            end
            default:   reg_rdata = '0;
        endcase
    end

    // R8
    irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_rd && !done_pulse) |=> !irq);

    // R7
    irq_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> done_q);

endmodule

// File: rtl/dma_cnt.sv
// Memory address and word count counters. Software loads them directly;
// the sequencer steps them once per moved word. Assumes AW, CW <= DW.
module dma_cnt #(
    parameter int DW = 16,
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_addr,
    input  logic          ld_cnt,
    input  logic [DW-1:0] ld_data,
    input  logic          step,
    input  logic          busy,
    output logic [AW-1:0] cur_addr,
    output logic [CW-1:0] cur_cnt,
    output logic          cnt_zero,
    output logic          cnt_last
);

    localparam logic [AW-1:0] ADDR_INC = AW'(1);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);

    // Address counter: load from software, advance per word.
    always_ff @(posedge clk) begin
        if (!rst_n)       cur_addr <= '0;
        else if (ld_addr) cur_addr <= AW'(ld_data);
        else if (step)    cur_addr <= cur_addr + ADDR_INC;
    end

    // Word counter: load from software, fall per word.
    always_ff @(posedge clk) begin
        if (!rst_n)      cur_cnt <= '0;
        else if (ld_cnt) cur_cnt <= CW'(ld_data);
        else if (step)   cur_cnt <= cur_cnt - CNT_ONE;
    end

    // Flags the sequencer decides on.
    always_comb begin
        cnt_zero = (cur_cnt == '0);
        cnt_last = (cur_cnt == CNT_ONE);
    end

    // R9
    cfg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_addr || ld_cnt) |-> !busy);

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !cnt_zero);

endmodule

// File: rtl/dma_seq.sv
// Per-word sequencer: waits for the device, requests the bus, owns it for
// one cycle to move one word, then releases it. Assumes the arbiter holds
// bus_gnt while bus_req stays high, memory read data is valid in the owned
// cycle, and dev_wready, once seen, holds until dev_wstrobe.
module dma_seq
    import dma_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          dir,
    input  logic          cnt_zero,
    input  logic          cnt_last,
    input  logic          bus_gnt,
    input  logic [DW-1:0] bus_rdata,
    input  logic          dev_rvalid,
    input  logic [DW-1:0] dev_rdata,
    input  logic          dev_wready,
    output logic          busy,
    output logic          done_pulse,
    output logic          step,
    output logic          bus_req,
    output logic          bus_own,
    output logic          bus_we,
    output logic          bus_re,
    output logic [DW-1:0] bus_wdata,
    output logic          dev_rack,
    output logic [DW-1:0] dev_wdata,
    output logic          dev_wstrobe
);

    seq_state_t state_q, state_d;
    logic [DW-1:0] hold_q;
    logic          dev_ok;

    // Device side readiness for the programmed direction.
    always_comb dev_ok = dir ? dev_wready : dev_rvalid;

    // Next state and per-cycle strobes.
    always_comb begin
        state_d     = state_q;
        done_pulse  = 1'b0;
        step        = 1'b0;
        bus_req     = 1'b0;
        bus_own     = 1'b0;
        dev_rack    = 1'b0;
        dev_wstrobe = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (go) begin
                    if (cnt_zero) done_pulse = 1'b1;
                    else          state_d    = ST_WAIT_DEV;
                end
            end
            ST_WAIT_DEV: begin
                if (dev_ok) begin
                    dev_rack = !dir;
                    state_d  = ST_REQ;
                end
            end
            ST_REQ: begin
                bus_req = 1'b1;
                if (bus_gnt) state_d = ST_XFER;
            end
            ST_XFER: begin
                bus_req     = 1'b1;
                bus_own     = 1'b1;
                step        = 1'b1;
                dev_wstrobe = dir;
                if (cnt_last) begin
                    done_pulse = 1'b1;
                    state_d    = ST_IDLE;
                end else begin
                    state_d = ST_WAIT_DEV;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Holding register for the word taken from the device.
    always_ff @(posedge clk) begin
        if (!rst_n)        hold_q <= '0;
        else if (dev_rack) hold_q <= dev_rdata;
    end

    // Bus and device data paths.
    always_comb begin
        busy      = (state_q != ST_IDLE);
        bus_we    = bus_own && !dir;
        bus_re    = bus_own && dir;
        bus_wdata = bus_we ? hold_q : '0;
        dev_wdata = dev_wstrobe ? bus_rdata : '0;
    end

    // R5
    own_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we || bus_re) |-> (bus_req && bus_gnt));

    // R5
    xfer_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_own |=> (!bus_own && !bus_req));

    // R11
    dev_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> ($past(dev_rvalid) || $past(dev_wready)));

    // R12
    gnt_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> (bus_req && !bus_we && !bus_re));

endmodule

// File: rtl/cyc_steal_dma.sv
// Top of the single-channel cycle-stealing transfer engine: register port,
// counters and per-word sequencer. Assumes one synchronous shared bus with
// a request/grant arbiter and a device placed next to the engine.
module cyc_steal_dma #(
    parameter int DW   = 16,
    parameter int AW   = 16,
    parameter int CW   = 16,
    parameter int DEVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [2:0]      reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            irq,
    output logic            bus_req,
    input  logic            bus_gnt,
    output logic [AW-1:0]   bus_addr,
    output logic            bus_we,
    output logic            bus_re,
    output logic [DW-1:0]   bus_wdata,
    input  logic [DW-1:0]   bus_rdata,
    output logic [DEVW-1:0] dev_sel,
    input  logic            dev_rvalid,
    input  logic [DW-1:0]   dev_rdata,
    output logic            dev_rack,
    input  logic            dev_wready,
    output logic [DW-1:0]   dev_wdata,
    output logic            dev_wstrobe
);

    logic          busy, done_pulse, step, go, dir;
    logic          ld_addr, ld_cnt, cnt_zero, cnt_last, bus_own;
    logic [AW-1:0] cur_addr;
    logic [CW-1:0] cur_cnt;

    dma_regs #(.DW(DW), .AW(AW), .CW(CW), .DEVW(DEVW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy       (busy),
        .done_pulse (done_pulse),
        .cur_addr   (cur_addr),
        .cur_cnt    (cur_cnt),
        .go         (go),
        .dir        (dir),
        .dev_sel    (dev_sel),
        .ld_addr    (ld_addr),
        .ld_cnt     (ld_cnt),
        .irq        (irq)
    );

    dma_cnt #(.DW(DW), .AW(AW), .CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_addr  (ld_addr),
        .ld_cnt   (ld_cnt),
        .ld_data  (reg_wdata),
        .step     (step),
        .busy     (busy),
        .cur_addr (cur_addr),
        .cur_cnt  (cur_cnt),
        .cnt_zero (cnt_zero),
        .cnt_last (cnt_last)
    );

    dma_seq #(.DW(DW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (go),
        .dir         (dir),
        .cnt_zero    (cnt_zero),
        .cnt_last    (cnt_last),
        .bus_gnt     (bus_gnt),
        .bus_rdata   (bus_rdata),
        .dev_rvalid  (dev_rvalid),
        .dev_rdata   (dev_rdata),
        .dev_wready  (dev_wready),
        .busy        (busy),
        .done_pulse  (done_pulse),
        .step        (step),
        .bus_req     (bus_req),
        .bus_own     (bus_own),
        .bus_we      (bus_we),
        .bus_re      (bus_re),
        .bus_wdata   (bus_wdata),
        .dev_rack    (dev_rack),
        .dev_wdata   (dev_wdata),
        .dev_wstrobe (dev_wstrobe)
    );

    // Address lines carry the counter only in the owned cycle.
    always_comb bus_addr = bus_own ? cur_addr : '0;

    // R10
    zero_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && cnt_zero) |=> (irq && !busy && !bus_req));

endmodule

// File: tb/cyc_steal_dma_tb.sv
// Directed bench: one task per scenario, with models of the memory, the
// arbiter and the device.
module cyc_steal_dma_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int AW = 16;
    localparam int DEVW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic irq, bus_req, bus_we, bus_re, dev_rack, dev_wstrobe;
    logic bus_gnt = 1'b0;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata, dev_rdata, dev_wdata;
    logic [DEVW-1:0] dev_sel;
    logic dev_rvalid, dev_wready;

    int total = 0, bad = 0;
    logic [DW-1:0] tmem [0:255];
    logic [DW-1:0] dq [0:15];
    logic [DW-1:0] cap [0:15];
    int didx = 0, dlen = 0, cidx = 0;
    logic dev_en = 1'b0, wr_en = 1'b0;
    int gnt_lat = 0, gcnt = 0;
    int own_cnt = 0, bad_own = 0, adjacent = 0;
    logic own_prev = 1'b0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cyc_steal_dma u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .dev_sel(dev_sel), .dev_rvalid(dev_rvalid),
        .dev_rdata(dev_rdata), .dev_rack(dev_rack), .dev_wready(dev_wready),
        .dev_wdata(dev_wdata), .dev_wstrobe(dev_wstrobe)
    );

    // Memory, device and arbiter models
    assign bus_rdata  = tmem[bus_addr[7:0]];
    assign dev_rvalid = dev_en && (didx < dlen);
    assign dev_rdata  = dq[didx[3:0]];
    assign dev_wready = wr_en;

    always @(posedge clk) begin
        if (bus_we) tmem[bus_addr[7:0]] <= bus_wdata;
        if (dev_rack) didx <= didx + 1;
        if (dev_wstrobe) begin
            cap[cidx[3:0]] <= dev_wdata;
            cidx <= cidx + 1;
        end
        if (!rst_n || !bus_req) begin
            bus_gnt <= 1'b0;
            gcnt <= 0;
        end else if (gcnt >= gnt_lat) bus_gnt <= 1'b1;
        else gcnt <= gcnt + 1;
    end

    // Bus monitor: owned cycles, grant-less cycles, adjacent ownerships
    always @(posedge clk) begin
        if (rst_n) begin
            if (bus_we || bus_re) own_cnt <= own_cnt + 1;
            if ((bus_we || bus_re) && !bus_gnt) bad_own <= bad_own + 1;
            if (own_prev && (bus_we || bus_re || bus_req)) adjacent <= adjacent + 1;
            own_prev <= bus_we || bus_re;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_irq(input int lim, input string req);
        int n = 0;
        while (!irq && n < lim) begin
            @(negedge clk);
            n++;
        end
        chk(req, "irq after block", {31'd0, irq}, 32'd1);
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        chk("R1", "irq", {31'd0, irq}, 0);
        chk("R1", "bus_req", {31'd0, bus_req}, 0);
        reg_read(3'd4, v); chk("R1", "status", v, 0);
        reg_read(3'd2, v); chk("R1", "maddr", v, 0);
        reg_read(3'd3, v); chk("R1", "count", v, 0);
    endtask

    task automatic t_dev2mem();
        logic [DW-1:0] v;
        int o0 = own_cnt;
        for (int i = 0; i < 4; i++) dq[i] = 16'hA100 + 16'(i * 3);
        didx = 0; dlen = 4; dev_en = 1'b1; gnt_lat = 0;
        reg_write(3'd1, 16'h005A);
        reg_write(3'd2, 16'h0010);
        reg_write(3'd3, 16'd4);
        reg_read(3'd2, v); chk("R2", "maddr readback", v, 16'h0010);
        reg_write(3'd0, 16'h0001);
        chk("R2", "dev_sel", {24'd0, dev_sel}, 32'h5A);
        wait_irq(200, "R7");
        for (int i = 0; i < 4; i++)
            chk("R3", "memory word", tmem[8'h10 + i], 16'hA100 + 16'(i * 3));
        chk("R3", "one bus cycle per word", own_cnt - o0, 4);
        reg_read(3'd2, v); chk("R6", "final maddr", v, 16'h0014);
        reg_read(3'd3, v); chk("R6", "final count", v, 0);
        reg_read(3'd4, v); chk("R7", "status done/irq", v, 16'h0006);
        chk("R8", "irq cleared by status read", {31'd0, irq}, 0);
        reg_read(3'd4, v); chk("R8", "done kept", v, 16'h0002);
        dev_en = 1'b0;
    endtask

    task automatic t_mem2dev();
        logic [DW-1:0] v;
        int o0 = own_cnt;
        for (int i = 0; i < 3; i++) tmem[8'h40 + i] = 16'h5C00 + 16'(i * 7);
        cidx = 0; wr_en = 1'b1; gnt_lat = 3;
        reg_write(3'd2, 16'h0040);
        reg_write(3'd3, 16'd3);
        reg_write(3'd0, 16'h0003);
        reg_read(3'd0, v); chk("R2", "ctrl dir readback", v, 16'h0002);
        wait_irq(300, "R7");
        chk("R4", "words to device", cidx, 3);
        for (int i = 0; i < 3; i++)
            chk("R4", "device word", cap[i], 16'h5C00 + 16'(i * 7));
        chk("R4", "one bus cycle per word", own_cnt - o0, 3);
        reg_read(3'd2, v); chk("R6", "final maddr", v, 16'h0043);
        reg_read(3'd4, v);
        wr_en = 1'b0;
    endtask

    task automatic t_busy_ignore();
        logic [DW-1:0] v;
        int o0 = own_cnt;
        int c0;
        dq[0] = 16'hBEE1; dq[1] = 16'hBEE2;
        didx = 0; dlen = 2; dev_en = 1'b0; gnt_lat = 1;
        reg_write(3'd2, 16'h0020);
        reg_write(3'd3, 16'd2);
        reg_write(3'd0, 16'h0001);
        repeat (4) @(negedge clk);
        chk("R11", "no request before device valid", {31'd0, bus_req}, 0);
        reg_read(3'd4, v); chk("R9", "busy set", v, 16'h0001);
        reg_write(3'd2, 16'h0099);
        reg_write(3'd3, 16'd7);
        reg_write(3'd0, 16'h0003);
        reg_read(3'd2, v); chk("R9", "maddr kept", v, 16'h0020);
        reg_read(3'd3, v); chk("R9", "count kept", v, 16'd2);
        reg_read(3'd0, v); chk("R9", "dir kept", v, 0);
        chk("R11", "no bus cycle while device idle", own_cnt - o0, 0);
        c0 = cidx;
        dev_en = 1'b1;
        wait_irq(200, "R7");
        chk("R9", "word 0 placed", tmem[8'h20], 16'hBEE1);
        chk("R9", "word 1 placed", tmem[8'h21], 16'hBEE2);
        chk("R9", "direction unchanged", cidx - c0, 0);
        chk("R3", "two bus cycles", own_cnt - o0, 2);
        reg_read(3'd4, v);
        dev_en = 1'b0;
    endtask

    task automatic t_zero();
        logic [DW-1:0] v;
        int o0 = own_cnt;
        reg_write(3'd3, 16'd0);
        reg_write(3'd0, 16'h0001);
        chk("R10", "irq at once", {31'd0, irq}, 1);
        chk("R10", "no request", {31'd0, bus_req}, 0);
        reg_read(3'd4, v); chk("R10", "status done", v, 16'h0006);
        chk("R10", "no bus cycle", own_cnt - o0, 0);
    endtask

    task automatic t_grant_wait();
        logic [DW-1:0] v;
        int o0 = own_cnt;
        dq[0] = 16'h7E57;
        didx = 0; dlen = 1; dev_en = 1'b1; gnt_lat = 20;
        reg_write(3'd2, 16'h0030);
        reg_write(3'd3, 16'd1);
        reg_write(3'd0, 16'h0001);
        repeat (10) @(negedge clk);
        chk("R12", "request held", {31'd0, bus_req}, 1);
        chk("R12", "no cycle before grant", own_cnt - o0, 0);
        wait_irq(200, "R12");
        chk("R12", "word after grant", tmem[8'h30], 16'h7E57);
        chk("R12", "single cycle", own_cnt - o0, 1);
        reg_read(3'd4, v);
        dev_en = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) tmem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dev2mem();
        t_mem2dev();
        t_busy_ignore();
        t_zero();
        t_grant_wait();
        chk("R5", "grant-less bus cycles", bad_own, 0);
        chk("R5", "request or ownership right after ownership", adjacent, 0);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule